// File: doc/BRIEF.md
# Transfer descriptor status updater

This unit closes out one transfer descriptor after its bus transaction has finished. A schedule walker hands it the descriptor's control word, its token word, a transaction outcome code and the byte count that moved. One clock later the unit returns four things. The first is the rewritten control word, with a flag saying whether it differs from the input. The second is a two-bit interrupt request mask, one bit for completion and one for a short packet. The third is a bus-error flag and a PID-error flag. The last is a disposition telling the walker whether to advance, skip, or abandon the frame.

The token is decoded on the same path into its packet identifier, device address, endpoint and maximum packet length. The walker uses these fields to issue the transaction and to size the buffer. The unit itself moves no data and follows no links.

Outcome codes on `result_i`: 0 success, 1 stall, 2 NAK, 3 babble, 4 no device; 5 to 7 are treated like no device. Disposition codes on `disp_o`: 0 advance (success), 1 skip, 2 fatal. Recognised PIDs: IN 0x69, OUT 0xE1, SETUP 0x2D.

Top module: `td_status_update`

## Requirements
- R1: Token fields decode as PID = token[7:0], device address = token[14:8], endpoint = token[18:15], and maximum length = (token[31:21] + 1) mod 2048, so a field of 0x7FF means a zero-length maximum.
- R2: A descriptor whose active bit (ctrl bit 23) is clear returns the control word unchanged, disposition skip, a zero interrupt mask and no error flags.
- R3: An active descriptor with a PID other than IN, OUT or SETUP raises the PID-error flag, returns fatal, and leaves the control word and interrupt mask untouched.
- R4: For an active descriptor with a known PID, interrupt-on-complete (bit 24) sets mask bit 0 whatever the outcome, and isochronous select (bit 25) clears the active bit whatever the outcome.
- R5: On success, bits 10:0 become (count − 1) mod 2048, the active bit (23) and NAK bit (19) are cleared, and the disposition is advance unless R6 or R7 applies.
- R6: On success for an IN token whose count exceeds the maximum length, the length field is still written, then babble (bit 20) and stall (bit 22) are set, active is cleared and the disposition is fatal.
- R7: On success for an IN token with short-packet detect (bit 29) set and a count below the maximum, mask bit 1 is set and the disposition is skip.
- R8: A stall outcome sets bit 22, clears active, leaves the length field alone and returns skip.
- R9: A babble outcome sets bits 20 and 22, clears active and returns fatal.
- R10: A NAK outcome sets bit 19 and returns skip. For a SETUP token, the NAK outcome also takes the error path of R11.
- R11: On the error path, timeout (bit 18) is set. A nonzero error counter (bits 28:27) is decremented. When it reaches zero, active is cleared and the bus-error flag is raised. A counter already at zero stays at zero with active untouched. The disposition is skip.
- R12: The changed flag is high exactly when the returned control word differs from the input control word.
- R13: All outputs are registered. Results for inputs presented with `valid_i` high appear one clock later with `valid_o` high, and every output reads zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs carry a descriptor to close out |
| ctrl_i | input | 32 | Fetched control word |
| token_i | input | 32 | Fetched token word |
| result_i | input | 3 | Transaction outcome code |
| len_i | input | LEN_W | Bytes moved by the transaction |
| valid_o | output | 1 | Outputs belong to a presented descriptor |
| ctrl_o | output | 32 | Updated control word |
| changed_o | output | 1 | Control word needs writing back |
| irq_mask_o | output | 2 | Bit 0 completion request, bit 1 short-packet request |
| usb_err_o | output | 1 | Error counter ran out on this descriptor |
| pid_err_o | output | 1 | Unknown packet identifier |
| disp_o | output | 2 | 0 advance, 1 skip, 2 fatal |
| pid_o | output | 8 | Decoded PID |
| dev_addr_o | output | 7 | Decoded device address |
| endp_o | output | 4 | Decoded endpoint |
| max_len_o | output | 11 | Decoded maximum length |

## Verification
A directed set puts each outcome code through each PID class. It separates the NAK case for SETUP from the NAK case for IN and OUT. It places the IN byte count below, at and above the maximum, so the short-packet skip, a clean advance and the overflow babble each show up. The error counter is started at three, one and zero, which tells a plain decrement from exhaustion with the bus error and from the unlimited case. Descriptors that are inactive, carry an unknown PID, have isochronous select or a stale NAK bit, or use the all-ones length field are covered as well. These are followed by several hundred random descriptors, each compared field by field with a behavioural model.

// File: rtl/td_upd_pkg.sv
package td_upd_pkg;
  localparam int CW = 32;
  localparam int LW = 11;

  localparam int B_SPD   = 29;
  localparam int B_ERRHI = 28;
  localparam int B_ERRLO = 27;
  localparam int B_IOS   = 25;
  localparam int B_IOC   = 24;
  localparam int B_ACT   = 23;
  localparam int B_STALL = 22;
  localparam int B_BAB   = 20;
  localparam int B_NAK   = 19;
  localparam int B_TMO   = 18;

  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_SETUP = 8'h2D;

  typedef enum logic [2:0] {
    RES_OK     = 3'd0,
    RES_STALL  = 3'd1,
    RES_NAK    = 3'd2,
    RES_BABBLE = 3'd3,
    RES_NODEV  = 3'd4
  } res_e;

  typedef enum logic [1:0] {
    DISP_OK    = 2'd0,
    DISP_SKIP  = 2'd1,
    DISP_FATAL = 2'd2
  } disp_e;

  typedef struct packed {
    logic [7:0]    pid;
    logic [6:0]    dev;
    logic [3:0]    ep;
    logic [LW-1:0] max_len;
  } tok_t;
endpackage

// File: rtl/td_token_decode.sv
module td_token_decode
  import td_upd_pkg::*;
(
  input  logic [CW-1:0] token_i,
  output tok_t          tok_o
);
  always_comb begin
    tok_o.pid     = token_i[7:0];
    tok_o.dev     = token_i[14:8];
    tok_o.ep      = token_i[18:15];
    tok_o.max_len = token_i[31:21] + LW'(1);
  end
endmodule

// File: rtl/td_status_rules.sv
module td_status_rules
  import td_upd_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic [CW-1:0]    ctrl_i,
  input  tok_t             tok_i,
  input  logic [2:0]       result_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CW-1:0]    ctrl_o,
  output logic [1:0]       irq_o,
  output logic             usb_err_o,
  output logic             pid_err_o,
  output disp_e            disp_o
);
  logic known, is_in, is_setup, go_err, go_bab;
  logic [1:0]    err_dec;
  logic [LW-1:0] len_m1;
  logic [LEN_W-1:0] max_ext;

  assign is_in    = tok_i.pid == PID_IN;
  assign is_setup = tok_i.pid == PID_SETUP;
  assign known    = is_in || is_setup || (tok_i.pid == PID_OUT);
  assign len_m1   = len_i[LW-1:0] - LW'(1);
  assign max_ext  = LEN_W'(tok_i.max_len);
  assign err_dec  = ctrl_i[B_ERRHI:B_ERRLO] - 2'd1;

  always_comb begin
    ctrl_o    = ctrl_i;
    irq_o     = '0;
    usb_err_o = 1'b0;
    pid_err_o = 1'b0;
    disp_o    = DISP_SKIP;
    go_err    = 1'b0;
    go_bab    = 1'b0;
    if (!ctrl_i[B_ACT]) begin
      ctrl_o = ctrl_i;
    end else if (!known) begin
      pid_err_o = 1'b1;
      disp_o    = DISP_FATAL;
    end else begin
      irq_o[0] = ctrl_i[B_IOC];
      if (ctrl_i[B_IOS]) ctrl_o[B_ACT] = 1'b0;
      case (res_e'(result_i))
        RES_OK: begin
          ctrl_o[LW-1:0] = len_m1;
          ctrl_o[B_ACT]  = 1'b0;
          ctrl_o[B_NAK]  = 1'b0;
          disp_o         = DISP_OK;
          if (is_in) begin
            if (len_i > max_ext) go_bab = 1'b1;
            else if (ctrl_i[B_SPD] && (len_i < max_ext)) begin
              irq_o[1] = 1'b1;
              disp_o   = DISP_SKIP;
            end
          end
        end
        RES_STALL: begin
          ctrl_o[B_STALL] = 1'b1;
          ctrl_o[B_ACT]   = 1'b0;
        end
        RES_NAK: begin
          ctrl_o[B_NAK] = 1'b1;
          go_err        = is_setup;
        end
        RES_BABBLE: go_bab = 1'b1;
        default:    go_err = 1'b1;
      endcase
      if (go_bab) begin
        ctrl_o[B_BAB]   = 1'b1;
        ctrl_o[B_STALL] = 1'b1;
        ctrl_o[B_ACT]   = 1'b0;
        disp_o          = DISP_FATAL;
      end
      if (go_err) begin
        ctrl_o[B_TMO] = 1'b1;
        disp_o        = DISP_SKIP;
        // zero counter means unlimited retries
        if (ctrl_i[B_ERRHI:B_ERRLO] != 2'd0) begin
          ctrl_o[B_ERRHI:B_ERRLO] = err_dec;
          if (err_dec == 2'd0) begin
            ctrl_o[B_ACT] = 1'b0;
            usb_err_o     = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/td_status_update.sv
module td_status_update
  import td_upd_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [31:0]      ctrl_i,
  input  logic [31:0]      token_i,
  input  logic [2:0]       result_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             valid_o,
  output logic [31:0]      ctrl_o,
  output logic             changed_o,
  output logic [1:0]       irq_mask_o,
  output logic             usb_err_o,
  output logic             pid_err_o,
  output logic [1:0]       disp_o,
  output logic [7:0]       pid_o,
  output logic [6:0]       dev_addr_o,
  output logic [3:0]       endp_o,
  output logic [10:0]      max_len_o
);
  tok_t          tok;
  logic [CW-1:0] ctrl_n;
  logic [1:0]    irq_n;
  logic          uerr_n, perr_n;
  disp_e         disp_n;

  td_token_decode u_dec (
    .token_i (token_i),
    .tok_o   (tok)
  );

  td_status_rules #(.LEN_W(LEN_W)) u_rules (
    .ctrl_i    (ctrl_i),
    .tok_i     (tok),
    .result_i  (result_i),
    .len_i     (len_i),
    .ctrl_o    (ctrl_n),
    .irq_o     (irq_n),
    .usb_err_o (uerr_n),
    .pid_err_o (perr_n),
    .disp_o    (disp_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      ctrl_o     <= '0;
      changed_o  <= 1'b0;
      irq_mask_o <= '0;
      usb_err_o  <= 1'b0;
      pid_err_o  <= 1'b0;
      disp_o     <= '0;
      pid_o      <= '0;
      dev_addr_o <= '0;
      endp_o     <= '0;
      max_len_o  <= '0;
    end else begin
      valid_o    <= valid_i;
      ctrl_o     <= ctrl_n;
      changed_o  <= ctrl_n != ctrl_i;
      irq_mask_o <= irq_n;
      usb_err_o  <= uerr_n;
      pid_err_o  <= perr_n;
      disp_o     <= disp_n;
      pid_o      <= tok.pid;
      dev_addr_o <= tok.dev;
      endp_o     <= tok.ep;
      max_len_o  <= tok.max_len;
    end
  end

  // R13
  lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(ctrl_i[B_ACT])) |->
      (ctrl_o == $past(ctrl_i) && disp_o == DISP_SKIP && irq_mask_o == 2'b00));
  // R3
  pid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pid_err_o |-> (disp_o == DISP_FATAL && ctrl_o == $past(ctrl_i) && !changed_o));
  // R6
  fatal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_o == DISP_FATAL && !pid_err_o) |->
      (ctrl_o[B_BAB] && ctrl_o[B_STALL] && !ctrl_o[B_ACT]));
  // R7
  spd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask_o[1] |-> (disp_o == DISP_SKIP && $past(token_i[7:0]) == PID_IN));
  // R11
  uerr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_err_o |-> (ctrl_o[B_ERRHI:B_ERRLO] == 2'd0 && !ctrl_o[B_ACT] && ctrl_o[B_TMO]
                   && $past(ctrl_i[B_ERRHI:B_ERRLO]) == 2'd1));
endmodule

// File: tb/td_status_update_test.sv
module td_status_update_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] ctrl_i = '0, token_i = '0;
  logic [2:0]  result_i = '0;
  logic [11:0] len_i = '0;
  logic        valid_o, changed_o, usb_err_o, pid_err_o;
  logic [31:0] ctrl_o;
  logic [1:0]  irq_mask_o, disp_o;
  logic [7:0]  pid_o;
  logic [6:0]  dev_addr_o;
  logic [3:0]  endp_o;
  logic [10:0] max_len_o;

  always #5 clk = ~clk;

  td_status_update uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .ctrl_i(ctrl_i),
    .token_i(token_i), .result_i(result_i), .len_i(len_i),
    .valid_o(valid_o), .ctrl_o(ctrl_o), .changed_o(changed_o),
    .irq_mask_o(irq_mask_o), .usb_err_o(usb_err_o), .pid_err_o(pid_err_o),
    .disp_o(disp_o), .pid_o(pid_o), .dev_addr_o(dev_addr_o),
    .endp_o(endp_o), .max_len_o(max_len_o)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // expected bundle: ctrl,chg,irq,uerr,perr,disp,pid,dev,ep,max
  logic [31:0] e_ctrl;
  logic        e_chg, e_uerr, e_perr, pend = 0;
  logic [1:0]  e_irq, e_disp;
  logic [7:0]  e_pid;
  logic [6:0]  e_dev;
  logic [3:0]  e_ep;
  logic [10:0] e_max;
  string       e_tag;

  function automatic logic [31:0] mk_tok(input logic [7:0] pid, input int dev, input int ep, input int mx);
    logic [31:0] t;
    t = '0;
    t[7:0] = pid; t[14:8] = 7'(dev); t[18:15] = 4'(ep);
    t[31:21] = 11'((mx - 1) & 11'h7FF);
    return t;
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit spd, input int err, input bit ios,
                                          input bit ioc, input bit act);
    logic [31:0] c;
    c = 32'h0000_0123;
    c[29] = spd; c[28:27] = 2'(err); c[25] = ios; c[24] = ioc; c[23] = act;
    return c;
  endfunction

  task automatic model(input logic [31:0] c, input logic [31:0] t, input int r, input int n);
    int mx, ec;
    bit known, bab, err;
    logic [31:0] o;
    e_pid = t[7:0]; e_dev = t[14:8]; e_ep = t[18:15];
    mx = ((int'(t[31:21])) + 1) % 2048;
    e_max = 11'(mx);
    o = c; e_irq = 0; e_uerr = 0; e_perr = 0; e_disp = 1; bab = 0; err = 0;
    known = (t[7:0] == 8'h69) || (t[7:0] == 8'hE1) || (t[7:0] == 8'h2D);
    e_tag = "R1";
    if (!c[23]) e_tag = "R2 inactive";
    else if (!known) begin e_perr = 1; e_disp = 2; e_tag = "R3 bad pid"; end
    else begin
      e_irq[0] = c[24];
      if (c[25]) o[23] = 0;
      if (r == 0) begin
        o[10:0] = 11'((n + 2047) % 2048);
        o[23] = 0; o[19] = 0; e_disp = 0; e_tag = "R5 success";
        if (t[7:0] == 8'h69) begin
          if (n > mx) begin bab = 1; e_tag = "R6 overflow"; end
          else if (c[29] && n < mx) begin e_irq[1] = 1; e_disp = 1; e_tag = "R7 short"; end
        end
      end else if (r == 1) begin o[22] = 1; o[23] = 0; e_tag = "R8 stall"; end
      else if (r == 2) begin
        o[19] = 1; e_tag = "R10 nak";
        if (t[7:0] == 8'h2D) begin err = 1; e_tag = "R10 setup nak"; end
      end else if (r == 3) begin bab = 1; e_tag = "R9 babble"; end
      else begin err = 1; e_tag = "R11 error"; end
      if (bab) begin o[20] = 1; o[22] = 1; o[23] = 0; e_disp = 2; end
      if (err) begin
        o[18] = 1; e_disp = 1;
        ec = int'(c[28:27]);
        if (ec != 0) begin
          ec = ec - 1; o[28:27] = 2'(ec);
          if (ec == 0) begin o[23] = 0; e_uerr = 1; end
        end
      end
    end
    e_ctrl = o;
    e_chg = (o != c);
  endtask

  task automatic compare();
    checks++;
    if (pend) begin
      if (valid_o !== 1'b1 || ctrl_o !== e_ctrl || changed_o !== e_chg || irq_mask_o !== e_irq ||
          usb_err_o !== e_uerr || pid_err_o !== e_perr || disp_o !== e_disp || pid_o !== e_pid ||
          dev_addr_o !== e_dev || endp_o !== e_ep || max_len_o !== e_max) begin
        fails++;
        $display("FAIL %s/R12/R13: act v=%b c=%h ch=%b i=%b u=%b p=%b d=%0d tok=%h/%h/%h/%h exp c=%h ch=%b i=%b u=%b p=%b d=%0d tok=%h/%h/%h/%h",
                 e_tag, valid_o, ctrl_o, changed_o, irq_mask_o, usb_err_o, pid_err_o, disp_o,
                 pid_o, dev_addr_o, endp_o, max_len_o, e_ctrl, e_chg, e_irq, e_uerr, e_perr,
                 e_disp, e_pid, e_dev, e_ep, e_max);
      end
    end else if (valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R13: valid_o act=%b exp=0", valid_o);
    end
  endtask

  task automatic step(input logic [31:0] c, input logic [31:0] t, input int r, input int n);
    @(negedge clk);
    compare();
    ctrl_i = c; token_i = t; result_i = 3'(r); len_i = 12'(n); valid_i = 1'b1;
    model(c, t, r, n);
    pend = 1;
  endtask

  task automatic idle();
    @(negedge clk);
    compare();
    valid_i = 1'b0;
    pend = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    checks++;
    if (valid_o !== 0 || ctrl_o !== 0 || changed_o !== 0 || irq_mask_o !== 0 || usb_err_o !== 0 ||
        pid_err_o !== 0 || disp_o !== 0 || pid_o !== 0 || max_len_o !== 0) begin
      fails++;
      $display("FAIL R13: reset outputs act c=%h v=%b exp all zero", ctrl_o, valid_o);
    end
    rst_n = 1'b1;
    idle();
    step(mk_ctrl(0,3,0,1,0), mk_tok(8'h69,5,2,8), 0, 4);        // R2
    step(mk_ctrl(0,3,0,1,1), mk_tok(8'h55,5,2,8), 0, 4);        // R3
    step(mk_ctrl(0,3,0,1,1), mk_tok(8'hE1,9,3,8), 0, 8);        // R4 R5
    step(mk_ctrl(0,3,0,0,1), mk_tok(8'h69,1,1,8), 0, 0);        // R5 len 0
    step(mk_ctrl(1,3,0,0,1), mk_tok(8'h69,1,1,8), 0, 3);        // R7
    step(mk_ctrl(1,3,0,0,1), mk_tok(8'h69,1,1,8), 0, 8);        // R7 boundary equal
    step(mk_ctrl(0,3,0,1,1), mk_tok(8'h69,1,1,8), 0, 9);        // R6
    step(mk_ctrl(0,3,0,1,1), mk_tok(8'hE1,2,4,64), 1, 0);       // R8
    step(mk_ctrl(0,3,0,0,1), mk_tok(8'hE1,2,4,64), 3, 0);       // R9
    step(mk_ctrl(0,3,0,0,1), mk_tok(8'h69,2,4,64), 2, 0);       // R10
    step(mk_ctrl(0,3,0,0,1), mk_tok(8'h2D,0,0,8), 2, 0);        // R10 setup
    step(mk_ctrl(0,1,0,1,1), mk_tok(8'hE1,3,5,16), 4, 0);       // R11 exhaust
    step(mk_ctrl(0,0,0,0,1), mk_tok(8'hE1,3,5,16), 4, 0);       // R11 unlimited
    step(mk_ctrl(0,2,0,0,1), mk_tok(8'h69,3,5,16), 7, 0);       // R11 other code
    step(mk_ctrl(0,3,1,1,1), mk_tok(8'h69,3,5,16), 2, 0);       // R4 ios
    step(mk_ctrl(0,3,0,0,1), mk_tok(8'h69,127,15,0), 0, 0);     // R1 zero max
    step(mk_ctrl(0,3,0,0,1), mk_tok(8'h69,127,15,0), 0, 1);     // R1 R6
    step(mk_ctrl(0,3,0,0,1) | 32'h0008_0000, mk_tok(8'hE1,4,6,2047), 0, 2047); // R5 stale nak
    step(mk_ctrl(0,0,0,0,0), mk_tok(8'h00,0,0,1), 4, 0);        // R12 no change
    idle();
    idle();
    for (int k = 0; k < 600; k++) begin
      logic [31:0] c, t;
      int sel, mx;
      c = $urandom;
      if ((k % 8) != 0) c[23] = 1'b1;
      sel = $urandom_range(0, 9);
      mx = $urandom_range(0, 2047);
      t = mk_tok(sel < 4 ? 8'h69 : sel < 7 ? 8'hE1 : sel < 9 ? 8'h2D : 8'($urandom),
                 $urandom_range(0,127), $urandom_range(0,15), mx);
      if ((k % 5) == 0) idle();
      step(c, t, $urandom_range(0, 7),
           (k % 3 == 0) ? $urandom_range(0, 4095) : (mx + $urandom_range(0, 2)) % 4096 - ((k%2) ? 1 : 0) + ((mx == 0 && (k%2)) ? 1 : 0));
    end
    idle();
    idle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule